// File: doc/BRIEF.md
# Legacy System Address Range Decoder

This block decides where each processor cycle goes. A cycle is described by its address, a memory/I/O flag and a read/write flag. The block sends it to one of three places: main DRAM, the graphics/PCI port, or the downstream hub port. The choice depends on a small set of attribute registers that the block holds itself and that are written through a simple indexed write port. These registers cover the shadow enables for the expansion and BIOS segments below 1 MB, the top of main memory, the fixed memory hole, and the steering of monochrome-adapter cycles.

The result is a registered one-hot target select plus a flag that says the cycle hit DRAM. Both are valid one clock after the cycle strobe. Shadow segments have separate read and write enables, so a read and a write to the same address can go to different targets. A segment that is disabled is never remapped anywhere; its cycles simply go to the hub port.

Top module: `sysmap_steer`

## Requirements
- R1: After reset, `tgt_vld`, `tgt_sel` and `dram_hit` are all low. All shadow enables are off, the hole and both steering bits are off, and top of memory is 1 MB. As a result, a read of 0F8000h or 0C0000h goes to the hub port.
- R2: A cycle presented with `cyc_vld` high at a rising edge appears on `tgt_vld`/`tgt_sel` right after the next rising edge. `tgt_sel` encodes bit0 = DRAM, bit1 = graphics/PCI, bit2 = hub. Exactly one bit is set while `tgt_vld` is high, and all bits are zero otherwise. `dram_hit` is high exactly when bit0 is set.
- R3: Memory range 0C0000h–0DFFFFh is made of eight 16 KB segments, numbered by address bits [16:14]. Config index 0 holds the enables: bit 2n is the read enable and bit 2n+1 is the write enable of segment n. A cycle goes to DRAM when the enable for its direction is set, and to the hub port otherwise.
- R4: Memory range 0E0000h–0EFFFFh is made of four 16 KB segments, numbered by address bits [15:14]. Config index 1 holds the enables: bit 2n is read and bit 2n+1 is write. Routing works as in R3.
- R5: Memory range 0F0000h–0FFFFFh is one segment. Its read enable is config index 1 bit 8 and its write enable is bit 9. Routing works as in R3.
- R6: Memory cycles in 0B0000h–0B7FFFh, and I/O cycles at 3B4h, 3B5h, 3B8h, 3B9h, 3BAh and 3BFh, go to graphics only when both config index 3 bit1 (monochrome steer) and bit2 (VGA enable) are set. Otherwise they go to the hub port.
- R7: Every other I/O cycle goes to the hub port and never to DRAM. Memory below 0A0000h goes to DRAM. The rest of 0A0000h–0BFFFFh outside the monochrome window goes to the hub port.
- R8: Memory from 1 MB up to, but not including, top of memory goes to DRAM. Top of memory is config index 2 bits [11:0], in MB. Values above 1024 are stored as 1024.
- R9: When config index 3 bit0 is set, memory in F00000h–FFFFFFh that lies below top of memory goes to the hub port instead of DRAM.
- R10: Memory at or above top of memory goes to graphics/PCI. This includes the interrupt-controller windows and the top 2 MB boot area. Nothing at or above 1 GB ever reaches DRAM.
- R11: A config write at one rising edge applies to cycles presented at later edges. A cycle presented at the same edge as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | Cycle strobe |
| cyc_addr | input | 32 | Cycle address (I/O port in bits [15:0]) |
| cyc_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_wr | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Config write strobe |
| cfg_idx | input | 2 | Config register index |
| cfg_wdata | input | 16 | Config write data |
| tgt_vld | output | 1 | Registered target valid |
| tgt_sel | output | 3 | One-hot target: bit0 DRAM, bit1 graphics/PCI, bit2 hub |
| dram_hit | output | 1 | Cycle was routed to DRAM |

## Verification
The assertions assume that the cycle inputs are stable and known at every rising edge where `cyc_vld` is high. They also assume that for I/O cycles only bits [15:0] of the address carry meaning. The bench drives every input on the falling edge, leaves unused upper address bits at zero for I/O cycles, and samples the outputs one time step after the rising edge. Config writes happen on clocks of their own, except for one deliberate overlap that checks the old-value rule.

// File: rtl/sysmap_pkg.sv
package sysmap_pkg;
  typedef enum logic [2:0] {
    TGT_NONE = 3'b000,
    TGT_DRAM = 3'b001,
    TGT_GFX  = 3'b010,
    TGT_HUB  = 3'b100
  } tgt_e;

  localparam int CFG_IDX_W = 2;
  localparam logic [CFG_IDX_W-1:0] IDX_EXP  = 2'd0;
  localparam logic [CFG_IDX_W-1:0] IDX_EXT  = 2'd1;
  localparam logic [CFG_IDX_W-1:0] IDX_TOM  = 2'd2;
  localparam logic [CFG_IDX_W-1:0] IDX_CTRL = 2'd3;
endpackage

// File: rtl/sysmap_cfg.sv
module sysmap_cfg
  import sysmap_pkg::*;
#(
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4,
  parameter int TOM_W    = 12,
  parameter int TOM_CAP  = 1024,
  parameter int DATA_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CFG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [EXP_SEGS-1:0]  exp_rd,
  output logic [EXP_SEGS-1:0]  exp_wr,
  output logic [EXT_SEGS-1:0]  ext_rd,
  output logic [EXT_SEGS-1:0]  ext_wr,
  output logic                 bios_rd,
  output logic                 bios_wr,
  output logic [TOM_W-1:0]     tom_mb,
  output logic                 hole_en,
  output logic                 mono_en,
  output logic                 vga_en
);
  localparam int EXP_BITS = 2 * EXP_SEGS;
  localparam int EXT_BITS = 2 * EXT_SEGS + 2;
  localparam logic [TOM_W-1:0] TOM_RST = TOM_W'(1);
  localparam logic [TOM_W-1:0] TOM_MAX = TOM_W'(TOM_CAP);

  logic [EXP_BITS-1:0] exp_q, exp_d;
  logic [EXT_BITS-1:0] ext_q, ext_d;
  logic [TOM_W-1:0]    tom_q, tom_d, tom_wr;
  logic [2:0]          ctl_q, ctl_d;

  always_comb begin
    exp_d  = exp_q;
    ext_d  = ext_q;
    tom_d  = tom_q;
    ctl_d  = ctl_q;
    tom_wr = wr_data[TOM_W-1:0];
    if (tom_wr > TOM_MAX) tom_wr = TOM_MAX;
    if (wr_en) begin
      unique case (wr_idx)
        IDX_EXP:  exp_d = wr_data[EXP_BITS-1:0];
        IDX_EXT:  ext_d = wr_data[EXT_BITS-1:0];
        IDX_TOM:  tom_d = tom_wr;
        default:  ctl_d = wr_data[2:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      ext_q <= '0;
      tom_q <= TOM_RST;
      ctl_q <= '0;
    end else if (wr_en) begin
      exp_q <= exp_d;
      ext_q <= ext_d;
      tom_q <= tom_d;
      ctl_q <= ctl_d;
    end
  end

  for (genvar g = 0; g < EXP_SEGS; g++) begin : g_exp
    assign exp_rd[g] = exp_q[2*g];
    assign exp_wr[g] = exp_q[2*g+1];
  end
  for (genvar g = 0; g < EXT_SEGS; g++) begin : g_ext
    assign ext_rd[g] = ext_q[2*g];
    assign ext_wr[g] = ext_q[2*g+1];
  end
  assign bios_rd = ext_q[2*EXT_SEGS];
  assign bios_wr = ext_q[2*EXT_SEGS+1];
  assign tom_mb  = tom_q;
  assign hole_en = ctl_q[0];
  assign mono_en = ctl_q[1];
  assign vga_en  = ctl_q[2];
endmodule

// File: rtl/sysmap_region.sv
module sysmap_region
  import sysmap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4,
  parameter int TOM_W    = 12,
  parameter int HOLE_MB  = 15
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                is_io,
  input  logic                is_wr,
  input  logic [EXP_SEGS-1:0] exp_rd,
  input  logic [EXP_SEGS-1:0] exp_wr,
  input  logic [EXT_SEGS-1:0] ext_rd,
  input  logic [EXT_SEGS-1:0] ext_wr,
  input  logic                bios_rd,
  input  logic                bios_wr,
  input  logic [TOM_W-1:0]    tom_mb,
  input  logic                hole_en,
  input  logic                mono_en,
  input  logic                vga_en,
  output tgt_e                tgt
);
  localparam int MB_W   = ADDR_W - 20;
  localparam int EXP_IW = $clog2(EXP_SEGS);
  localparam int EXT_IW = $clog2(EXT_SEGS);

  logic [EXP_SEGS-1:0] exp_ok;
  logic [EXT_SEGS-1:0] ext_ok;
  logic [MB_W-1:0]     addr_mb;
  logic [EXP_IW-1:0]   exp_idx;
  logic [EXT_IW-1:0]   ext_idx;
  logic                bios_ok, mono_port, below_tom;
  tgt_e                mono_tgt;

  for (genvar g = 0; g < EXP_SEGS; g++) begin : g_exp_ok
    assign exp_ok[g] = is_wr ? exp_wr[g] : exp_rd[g];
  end
  for (genvar g = 0; g < EXT_SEGS; g++) begin : g_ext_ok
    assign ext_ok[g] = is_wr ? ext_wr[g] : ext_rd[g];
  end

  assign bios_ok   = is_wr ? bios_wr : bios_rd;
  assign addr_mb   = addr[ADDR_W-1:20];
  assign exp_idx   = addr[14+EXP_IW-1:14];
  assign ext_idx   = addr[14+EXT_IW-1:14];
  assign below_tom = ({{(MB_W > TOM_W ? MB_W - TOM_W : 0){1'b0}}, tom_mb} > MB_W'(addr_mb));
  assign mono_tgt  = (mono_en && vga_en) ? TGT_GFX : TGT_HUB;

  always_comb begin
    mono_port = 1'b0;
    if (addr[15:4] == 12'h03B) begin
      unique case (addr[3:0])
        4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hF: mono_port = 1'b1;
        default:                            mono_port = 1'b0;
      endcase
    end
  end

  always_comb begin
    tgt = TGT_HUB;
    if (is_io) begin
      tgt = mono_port ? mono_tgt : TGT_HUB;
    end else if (addr_mb == '0) begin
      unique case (addr[19:16])
        4'hA:       tgt = TGT_HUB;
        4'hB:       tgt = addr[15] ? TGT_HUB : mono_tgt;
        4'hC, 4'hD: tgt = exp_ok[exp_idx] ? TGT_DRAM : TGT_HUB;
        4'hE:       tgt = ext_ok[ext_idx] ? TGT_DRAM : TGT_HUB;
        4'hF:       tgt = bios_ok ? TGT_DRAM : TGT_HUB;
        default:    tgt = TGT_DRAM;
      endcase
    end else if (below_tom) begin
      tgt = (hole_en && addr_mb == MB_W'(HOLE_MB)) ? TGT_HUB : TGT_DRAM;
    end else begin
      tgt = TGT_GFX;
    end
  end
endmodule

// File: rtl/sysmap_steer.sv
module sysmap_steer
  import sysmap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 16,
  parameter int EXP_SEGS = 8,
  parameter int EXT_SEGS = 4,
  parameter int TOM_W    = 12,
  parameter int TOM_CAP  = 1024,
  parameter int HOLE_MB  = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cyc_vld,
  input  logic [ADDR_W-1:0]    cyc_addr,
  input  logic                 cyc_is_io,
  input  logic                 cyc_wr,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic                 tgt_vld,
  output logic [2:0]           tgt_sel,
  output logic                 dram_hit
);
  logic [EXP_SEGS-1:0] exp_rd, exp_wr;
  logic [EXT_SEGS-1:0] ext_rd, ext_wr;
  logic                bios_rd, bios_wr, hole_en, mono_en, vga_en;
  logic [TOM_W-1:0]    tom_mb;
  tgt_e                dec;

  logic       vld_q, vld_d, hit_q, hit_d;
  logic [2:0] sel_q, sel_d;

  sysmap_cfg #(
    .EXP_SEGS(EXP_SEGS), .EXT_SEGS(EXT_SEGS), .TOM_W(TOM_W),
    .TOM_CAP(TOM_CAP), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_data(cfg_wdata),
    .exp_rd(exp_rd), .exp_wr(exp_wr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .bios_rd(bios_rd), .bios_wr(bios_wr), .tom_mb(tom_mb),
    .hole_en(hole_en), .mono_en(mono_en), .vga_en(vga_en)
  );

  sysmap_region #(
    .ADDR_W(ADDR_W), .EXP_SEGS(EXP_SEGS), .EXT_SEGS(EXT_SEGS),
    .TOM_W(TOM_W), .HOLE_MB(HOLE_MB)
  ) u_region (
    .addr(cyc_addr), .is_io(cyc_is_io), .is_wr(cyc_wr),
    .exp_rd(exp_rd), .exp_wr(exp_wr), .ext_rd(ext_rd), .ext_wr(ext_wr),
    .bios_rd(bios_rd), .bios_wr(bios_wr), .tom_mb(tom_mb),
    .hole_en(hole_en), .mono_en(mono_en), .vga_en(vga_en), .tgt(dec)
  );

  always_comb begin
    vld_d = cyc_vld;
    sel_d = cyc_vld ? dec : TGT_NONE;
    hit_d = cyc_vld && (dec == TGT_DRAM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sel_q <= 3'b000;
      hit_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sel_q <= sel_d;
      hit_q <= hit_d;
    end
  end

  assign tgt_vld  = vld_q;
  assign tgt_sel  = sel_q;
  assign dram_hit = hit_q;
endmodule

// File: rtl/sysmap_steer_chk.sv
module sysmap_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_vld,
  input logic [31:0] cyc_addr,
  input logic        cyc_is_io,
  input logic        tgt_vld,
  input logic [2:0]  tgt_sel,
  input logic        dram_hit
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_vld |-> $countones(tgt_sel) == 1);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_vld |-> (tgt_sel == 3'b000 && !dram_hit));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_vld |=> tgt_vld);

  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_vld |=> !tgt_vld);

  // R7
  io_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && cyc_is_io) |=> (!dram_hit && !tgt_sel[0]));

  // R7
  io_other_hub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && cyc_is_io && cyc_addr[15:4] != 12'h03B) |=> tgt_sel == 3'b100);

  // R10
  high_no_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && !cyc_is_io && cyc_addr[31:30] != 2'b00) |=> (!tgt_sel[0] && !dram_hit));
endmodule

bind sysmap_steer sysmap_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr),
  .cyc_is_io(cyc_is_io), .tgt_vld(tgt_vld), .tgt_sel(tgt_sel), .dram_hit(dram_hit)
);

// File: tb/sim_sysmap_steer.sv
`timescale 1ns/1ps
module sim_sysmap_steer;
  localparam logic [2:0] DR = 3'b001, GX = 3'b010, HB = 3'b100;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_vld, cyc_is_io, cyc_wr, cfg_we;
  logic [31:0] cyc_addr;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_wdata;
  logic        tgt_vld, dram_hit;
  logic [2:0]  tgt_sel;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sysmap_steer u0 (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_addr(cyc_addr),
    .cyc_is_io(cyc_is_io), .cyc_wr(cyc_wr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .tgt_vld(tgt_vld), .tgt_sel(tgt_sel), .dram_hit(dram_hit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] idx, logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cycle(string req, logic [31:0] addr, logic io, logic wr, logic [2:0] exp);
    @(negedge clk);
    cyc_vld = 1'b1; cyc_addr = addr; cyc_is_io = io; cyc_wr = wr;
    @(posedge clk); #1;
    check(req, {29'd0, tgt_sel}, {29'd0, exp});
    check(req, {31'd0, dram_hit}, {31'd0, exp == DR});
    @(negedge clk);
    cyc_vld = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 vld", {31'd0, tgt_vld}, 0);
    check("R1 sel", {29'd0, tgt_sel}, 0);
    check("R1 hit", {31'd0, dram_hit}, 0);
    cycle("R1 bios read", 32'h000F8000, 0, 0, HB);
    cycle("R1 exp read", 32'h000C0000, 0, 0, HB);
    @(posedge clk); #1;
    check("R2 idle vld", {31'd0, tgt_vld}, 0);
    check("R2 idle sel", {29'd0, tgt_sel}, 0);
  endtask

  task automatic t_expansion();
    cfg_write(2'd0, 16'h80C4);
    cycle("R3 seg1 rd", 32'h000C4000, 0, 0, DR);
    cycle("R3 seg1 wr", 32'h000C4000, 0, 1, HB);
    cycle("R3 seg7 wr", 32'h000DC000, 0, 1, DR);
    cycle("R3 seg7 rd", 32'h000DFFFF, 0, 0, HB);
    cycle("R3 seg0 off", 32'h000C0000, 0, 1, HB);
    cycle("R3 seg3 rd", 32'h000CC000, 0, 0, DR);
    cycle("R3 seg3 wr", 32'h000CFFFF, 0, 1, DR);
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_wdata = 16'h0000;
    cyc_vld = 1'b1; cyc_addr = 32'h000C4000; cyc_is_io = 0; cyc_wr = 0;
    @(posedge clk); #1;
    check("R11 old value", {29'd0, tgt_sel}, {29'd0, DR});
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk); #1;
    check("R11 new value", {29'd0, tgt_sel}, {29'd0, HB});
    @(negedge clk);
    cyc_vld = 1'b0;
  endtask

  task automatic t_extended();
    cfg_write(2'd1, 16'h0110);
    cycle("R4 seg2 rd", 32'h000E8000, 0, 0, DR);
    cycle("R4 seg2 wr", 32'h000E8000, 0, 1, HB);
    cycle("R4 seg0 rd", 32'h000E0000, 0, 0, HB);
    cycle("R5 bios rd", 32'h000F8000, 0, 0, DR);
    cycle("R5 bios wr", 32'h000FFFFF, 0, 1, HB);
  endtask

  task automatic t_mono();
    cycle("R6 mem off", 32'h000B0000, 0, 0, HB);
    cycle("R6 io off", 32'h000003B4, 1, 0, HB);
    cfg_write(2'd3, 16'h0002);
    cycle("R6 mono only", 32'h000B0000, 0, 0, HB);
    cfg_write(2'd3, 16'h0004);
    cycle("R6 vga only", 32'h000003B8, 1, 1, HB);
    cfg_write(2'd3, 16'h0006);
    cycle("R6 mem both", 32'h000B7FFF, 0, 1, GX);
    cycle("R6 io 3BA", 32'h000003BA, 1, 0, GX);
    cycle("R6 io 3BF", 32'h000003BF, 1, 1, GX);
    cycle("R6 io 3B5", 32'h000003B5, 1, 0, GX);
    cycle("R7 io 3BB", 32'h000003BB, 1, 0, HB);
    cycle("R7 io other", 32'h00000080, 1, 1, HB);
    cycle("R7 mem B8000", 32'h000B8000, 0, 0, HB);
    cycle("R7 mem A0000", 32'h000A0000, 0, 0, HB);
    cycle("R7 mem low", 32'h0009FFFF, 0, 1, DR);
    cfg_write(2'd3, 16'h0000);
  endtask

  task automatic t_tom_hole();
    cycle("R10 reset tom", 32'h00100000, 0, 0, GX);
    cfg_write(2'd2, 16'd64);
    cycle("R8 below tom", 32'h03FFFFFF, 0, 0, DR);
    cycle("R8 at tom", 32'h04000000, 0, 1, GX);
    cycle("R9 hole off", 32'h00F00000, 0, 0, DR);
    cfg_write(2'd3, 16'h0001);
    cycle("R9 hole base", 32'h00F00000, 0, 0, HB);
    cycle("R9 hole top", 32'h00FFFFFF, 0, 1, HB);
    cycle("R9 above hole", 32'h01000000, 0, 0, DR);
    cycle("R9 below hole", 32'h00EFFFFF, 0, 0, DR);
    cfg_write(2'd2, 16'd15);
    cycle("R9 hole above tom", 32'h00F00000, 0, 0, GX);
    cfg_write(2'd2, 16'd2000);
    cycle("R8 clamp below", 32'h3FFFFFFF, 0, 0, DR);
    cycle("R8 clamp at", 32'h40000000, 0, 0, GX);
    cycle("R10 apic", 32'hFEC00000, 0, 1, GX);
    cycle("R10 apic2", 32'hFEE00010, 0, 0, GX);
    cycle("R10 boot", 32'hFFFFFFF0, 0, 0, GX);
  endtask

  initial begin
    rst_n = 1'b0; cyc_vld = 0; cyc_addr = '0; cyc_is_io = 0; cyc_wr = 0;
    cfg_we = 0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_expansion();
    t_write_timing();
    t_extended();
    t_mono();
    t_tom_hole();
    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule